// File: doc/BRIEF.md
# Codec ADC Control and Data Registers

This block is the device side of the register pair through which a host runs a multi-channel 10-bit converter. A host write to the control word enables the converter, picks one of eight inputs, chooses the reference source and, when the start bit is set along with the enable, begins a conversion. The host then polls the data word until its top bit reports a finished sample. The conversion itself is modelled by a latency counter, and the sample is taken from an input port that stands in for the analog converter.

When sync mode is chosen in the starting write, the conversion holds until a rising edge arrives on an external sync input. Only after that edge does the latency count run. Each finished conversion also issues a one-cycle done pulse. The interrupt logic uses this pulse as its ADC source (bit 11 there).

Top module: `codec_adc_regs`

## Requirements
- R1: After reset the control word and the data word both read 0x0000, `conv_busy` is 0 and `done_evt` is 0.
- R2: A write to the control address (default 0x66) stores enable (bit 15), external reference (bit 5), input select (bits 4:2, values 0 to 3 pick the +X, -X, +Y and -Y plates and 4 to 7 pick auxiliary inputs 0 to 3) and sync enable (bit 0). These fields read back in place, the start bit (bit 7) always reads 0, and `adc_on`, `ext_ref` and `chan_sel` follow the stored fields.
- R3: A control write with both bit 15 and bit 7 set is an accepted start. From the next cycle the valid flag reads 0 and `conv_busy` is 1.
- R4: With sync enable clear, the data word at the data address (default 0x68) reads bit 15 = 1 and bits 9:0 = `conv_sample` exactly CONV_LAT clocks after the accepted start, and not before. Bits 14:10 read 0.
- R5: `done_evt` is high for exactly one cycle, the same cycle in which the valid flag first reads 1.
- R6: With sync enable set in the starting write, the latency count begins only at a rising edge of `sync_in`. A level that is already high gives no start, and valid rises CONV_LAT clocks after the edge.
- R7: A control write with bit 7 set and bit 15 clear starts nothing. The data word is unchanged and `conv_busy` stays 0.
- R8: An accepted start during a conversion restarts it. Valid rises CONV_LAT clocks after the second start, and only one done pulse results.
- R9: A control write with bit 15 clear disables the converter and aborts any conversion. `conv_busy` falls at once, no done pulse follows, and the data word keeps its prior contents.
- R10: Writes to any other address change nothing, and reads of any other address return 0x0000.
- R11: A control write with enable set but start clear does not begin a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| conv_sample | input | RES_W | Converter output standing in for the analog front end |
| sync_in | input | 1 | External conversion sync |
| adc_on | output | 1 | Converter enabled |
| ext_ref | output | 1 | External reference selected |
| chan_sel | output | 3 | Selected input |
| conv_busy | output | 1 | Conversion waiting for sync or counting |
| done_evt | output | 1 | One-cycle conversion-done event |

## Verification
Random rounds vary the input select, the reference bit and the sample value. Each round checks the readback and the result, which separates field placement errors from capture errors. Directed patterns cover the other cases. A start without enable and an enable without start show whether the start decode needs both bits. A sync level held high before the start, followed by a real rising edge, shows whether the design detects an edge rather than a level. A second start during a conversion and a disable during a conversion show whether the counter reloads or aborts, and the done count shows that only one completion is reported.

// File: rtl/codec_adc_regs_pkg.sv
package codec_adc_regs_pkg;

    localparam int WORD_W         = 16;
    localparam int SEL_W          = 3;
    localparam int CTRL_EN_BIT    = 15;
    localparam int CTRL_START_BIT = 7;
    localparam int CTRL_XREF_BIT  = 5;
    localparam int CTRL_SEL_LSB   = 2;
    localparam int CTRL_SYNC_BIT  = 0;
    localparam int DATA_VALID_BIT = 15;

    typedef struct packed {
        logic             enable;
        logic             ext_ref;
        logic [SEL_W-1:0] sel;
        logic             sync_en;
    } adc_cfg_t;

    typedef enum logic [1:0] {
        CV_IDLE,
        CV_WAIT_SYNC,
        CV_RUN
    } cv_state_t;

    function automatic adc_cfg_t unpack_cfg(input logic [WORD_W-1:0] w);
        adc_cfg_t c;
        c.enable  = w[CTRL_EN_BIT];
        c.ext_ref = w[CTRL_XREF_BIT];
        c.sel     = w[CTRL_SEL_LSB +: SEL_W];
        c.sync_en = w[CTRL_SYNC_BIT];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] pack_cfg(input adc_cfg_t c);
        logic [WORD_W-1:0] w;
        w                           = '0;
        w[CTRL_EN_BIT]              = c.enable;
        w[CTRL_XREF_BIT]            = c.ext_ref;
        w[CTRL_SEL_LSB +: SEL_W]    = c.sel;
        w[CTRL_SYNC_BIT]            = c.sync_en;
        return w;
    endfunction

    function automatic logic is_start(input logic [WORD_W-1:0] w);
        return w[CTRL_EN_BIT] & w[CTRL_START_BIT];
    endfunction

endpackage

// File: rtl/cadc_reg_decode.sv
module cadc_reg_decode
    import codec_adc_regs_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h66
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output adc_cfg_t          cfg,
    output logic              start_req,
    output logic              start_sync,
    output logic              stop_req
);

    logic ctrl_hit;

    assign ctrl_hit   = wr_en && (wr_addr == CTRL_ADDR);
    assign start_req  = ctrl_hit && is_start(wr_data);
    assign start_sync = wr_data[CTRL_SYNC_BIT];
    assign stop_req   = ctrl_hit && !wr_data[CTRL_EN_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (ctrl_hit) begin
            cfg <= unpack_cfg(wr_data);
        end
    end

endmodule

// File: rtl/cadc_sync_edge.sv
module cadc_sync_edge (
    input  logic clk,
    input  logic rst,
    input  logic sync_in,
    output logic sync_rise
);

    logic sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 1'b0;
        end else begin
            sync_q <= sync_in;
        end
    end

    assign sync_rise = sync_in && !sync_q;

endmodule

// File: rtl/cadc_conv_timer.sv
module cadc_conv_timer
    import codec_adc_regs_pkg::*;
#(
    parameter int CONV_LAT = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic start_req,
    input  logic start_sync,
    input  logic stop_req,
    input  logic sync_rise,
    output logic busy,
    output logic waiting,
    output logic finish
);

    localparam int CNT_W = $clog2(CONV_LAT + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(CONV_LAT - 1);

    cv_state_t        state;
    logic [CNT_W-1:0] cnt;

    assign finish  = (state == CV_RUN) && (cnt == '0) && !start_req && !stop_req;
    assign busy    = (state != CV_IDLE);
    assign waiting = (state == CV_WAIT_SYNC);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CV_IDLE;
            cnt   <= '0;
        end else if (stop_req) begin
            state <= CV_IDLE;
            cnt   <= '0;
        end else if (start_req) begin
            state <= start_sync ? CV_WAIT_SYNC : CV_RUN;
            cnt   <= LOAD_VAL;
        end else begin
            case (state)
                CV_WAIT_SYNC: begin
                    if (sync_rise) begin
                        state <= CV_RUN;
                        cnt   <= LOAD_VAL;
                    end
                end
                CV_RUN: begin
                    if (cnt == '0) begin
                        state <= CV_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    state <= CV_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/cadc_result_reg.sv
module cadc_result_reg #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_req,
    input  logic             finish,
    input  logic [RES_W-1:0] sample,
    output logic             valid,
    output logic [RES_W-1:0] result,
    output logic             done_evt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid    <= 1'b0;
            result   <= '0;
            done_evt <= 1'b0;
        end else begin
            done_evt <= 1'b0;
            if (start_req) begin
                valid <= 1'b0;
            end else if (finish) begin
                valid    <= 1'b1;
                result   <= sample;
                done_evt <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/codec_adc_regs.sv
module codec_adc_regs
    import codec_adc_regs_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                RES_W     = 10,
    parameter int                CONV_LAT  = 24,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h66,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h68
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [15:0]       rd_data,
    input  logic [RES_W-1:0]  conv_sample,
    input  logic              sync_in,
    output logic              adc_on,
    output logic              ext_ref,
    output logic [2:0]        chan_sel,
    output logic              conv_busy,
    output logic              done_evt
);

    localparam int PAD_W = WORD_W - 1 - RES_W;

    adc_cfg_t         cfg;
    logic             start_req;
    logic             start_sync;
    logic             stop_req;
    logic             sync_rise;
    logic             cv_waiting;
    logic             finish;
    logic             data_valid;
    logic [RES_W-1:0] result;

    cadc_reg_decode #(
        .ADDR_W   (ADDR_W),
        .CTRL_ADDR(CTRL_ADDR)
    ) u_decode (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .cfg       (cfg),
        .start_req (start_req),
        .start_sync(start_sync),
        .stop_req  (stop_req)
    );

    cadc_sync_edge u_sync (
        .clk      (clk),
        .rst      (rst),
        .sync_in  (sync_in),
        .sync_rise(sync_rise)
    );

    cadc_conv_timer #(
        .CONV_LAT(CONV_LAT)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .start_req (start_req),
        .start_sync(start_sync),
        .stop_req  (stop_req),
        .sync_rise (sync_rise),
        .busy      (conv_busy),
        .waiting   (cv_waiting),
        .finish    (finish)
    );

    cadc_result_reg #(
        .RES_W(RES_W)
    ) u_result (
        .clk      (clk),
        .rst      (rst),
        .start_req(start_req),
        .finish   (finish),
        .sample   (conv_sample),
        .valid    (data_valid),
        .result   (result),
        .done_evt (done_evt)
    );

    assign adc_on   = cfg.enable;
    assign ext_ref  = cfg.ext_ref;
    assign chan_sel = cfg.sel;

    always_comb begin
        if (rd_addr == CTRL_ADDR) begin
            rd_data = pack_cfg(cfg);
        end else if (rd_addr == DATA_ADDR) begin
            rd_data = {data_valid, {PAD_W{1'b0}}, result};
        end else begin
            rd_data = '0;
        end
    end

endmodule

// File: rtl/codec_adc_regs_chk.sv
module codec_adc_regs_chk #(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h66
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [15:0]       wr_data,
    input logic              adc_on,
    input logic              conv_busy,
    input logic              done_evt,
    input logic              data_valid,
    input logic              cv_waiting
);

    logic ctl_wr;
    assign ctl_wr = wr_en && (wr_addr == CTRL_ADDR);

    p_start_clears_valid_r3: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && wr_data[15] && wr_data[7]) |=> (!data_valid && conv_busy));

    p_done_sets_valid_r4: assert property (@(posedge clk) disable iff (rst)
        done_evt |-> data_valid);

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        done_evt |=> !done_evt);

    p_wait_no_done_r6: assert property (@(posedge clk) disable iff (rst)
        cv_waiting |=> !done_evt);

    p_ignored_start_r7: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && wr_data[7] && !wr_data[15]) |=> (!conv_busy && $stable(data_valid)));

    p_off_not_busy_r9: assert property (@(posedge clk) disable iff (rst)
        !adc_on |-> !conv_busy);

endmodule

bind codec_adc_regs codec_adc_regs_chk #(
    .ADDR_W   (ADDR_W),
    .CTRL_ADDR(CTRL_ADDR)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .adc_on    (adc_on),
    .conv_busy (conv_busy),
    .done_evt  (done_evt),
    .data_valid(data_valid),
    .cv_waiting(cv_waiting)
);

// File: tb/codec_adc_regs_bench.sv
module codec_adc_regs_bench;

    localparam int LAT = 12;
    localparam logic [7:0] A_CTRL = 8'h66;
    localparam logic [7:0] A_DATA = 8'h68;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [9:0]  conv_sample = '0;
    logic        sync_in = 1'b0;
    logic        adc_on, ext_ref, conv_busy, done_evt;
    logic [2:0]  chan_sel;

    int errors = 0;
    int checks = 0;
    int done_cnt = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    codec_adc_regs #(.CONV_LAT(LAT)) u_codec_adc_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .conv_sample(conv_sample),
        .sync_in(sync_in), .adc_on(adc_on), .ext_ref(ext_ref), .chan_sel(chan_sel),
        .conv_busy(conv_busy), .done_evt(done_evt)
    );

    always @(negedge clk) if (!rst && done_evt) done_cnt++;

    function automatic logic [15:0] exp_ctrl(input logic [15:0] w);
        return w & 16'h803D;
    endfunction

    function automatic logic [15:0] exp_data(input logic v, input logic [9:0] s);
        return {v, 5'b0, s};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rdchk(input string req, input logic [7:0] a, input logic [15:0] exp);
        rd_addr = a;
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // called right after the cycle that accepted the start (or the sync edge)
    task automatic expect_result(input string req, input logic [9:0] s);
        idle(LAT - 1);
        rdchk(req, A_DATA, {1'b0, 15'(rd_data[14:0])} & 16'h03FF);
        chk(req, {15'b0, done_evt}, 16'h0);
        idle(1);
        rdchk(req, A_DATA, exp_data(1'b1, s));
        chk({req, " R5"}, {15'b0, done_evt}, 16'h1);
        idle(1);
        chk({req, " R5"}, {15'b0, done_evt}, 16'h0);
    endtask

    initial begin
        logic [15:0] w;
        logic [9:0]  s, last;
        int          dc;
        void'($urandom(32'd4242));
        idle(3);
        rst = 1'b0;
        idle(1);
        // R1 reset state
        rdchk("R1", A_CTRL, 16'h0);
        rdchk("R1", A_DATA, 16'h0);
        chk("R1", {14'b0, conv_busy, done_evt}, 16'h0);

        // R2/R3/R4 random rounds, sync off
        for (int i = 0; i < 8; i++) begin
            s = 10'($urandom);
            w = 16'h8080 | (16'($urandom % 8) << 2) | (16'($urandom % 2) << 5);
            conv_sample = s;
            wr(A_CTRL, w);
            rdchk("R2", A_CTRL, exp_ctrl(w));
            chk("R2", {12'b0, ext_ref, chan_sel}, {12'b0, w[5], w[4:2]});
            chk("R3", {14'b0, conv_busy, rd_data[15] & 1'b0}, 16'h2);
            rd_addr = A_DATA; #1;
            chk("R3", {15'b0, rd_data[15]}, 16'h0);
            idle(LAT - 1);
            rdchk("R4", A_DATA, exp_data(1'b0, rd_data[9:0]));
            idle(1);
            rdchk("R4", A_DATA, exp_data(1'b1, s));
            chk("R5", {15'b0, done_evt}, 16'h1);
            idle(1);
            chk("R5", {15'b0, done_evt}, 16'h0);
            last = s;
        end

        // R7 start without enable is ignored
        conv_sample = 10'h155;
        wr(A_CTRL, 16'h0080);
        idle(LAT + 2);
        rdchk("R7", A_DATA, exp_data(1'b1, last));
        chk("R7", {15'b0, conv_busy}, 16'h0);

        // R11 enable without start
        wr(A_CTRL, 16'h8008);
        chk("R11", {15'b0, adc_on}, 16'h1);
        idle(LAT + 2);
        rdchk("R11", A_DATA, exp_data(1'b1, last));
        chk("R11", {15'b0, conv_busy}, 16'h0);

        // R10 other address
        wr(8'h64, 16'h8080);
        idle(LAT + 2);
        rdchk("R10", A_CTRL, 16'h8008);
        rdchk("R10", 8'h64, 16'h0);
        rdchk("R10", A_DATA, exp_data(1'b1, last));

        // R6 sync: level already high gives no start
        sync_in = 1'b1;
        idle(2);
        conv_sample = 10'h2A7;
        wr(A_CTRL, 16'h8081);
        idle(LAT + 4);
        rdchk("R6", A_DATA, exp_data(1'b0, last));
        chk("R6", {15'b0, conv_busy}, 16'h1);
        sync_in = 1'b0;
        idle(3);
        sync_in = 1'b1;
        @(negedge clk);
        expect_result("R6", 10'h2A7);
        sync_in = 1'b0;
        last = 10'h2A7;

        // R8 restart mid conversion
        dc = done_cnt;
        conv_sample = 10'h0F0;
        wr(A_CTRL, 16'h8080);
        idle(5);
        conv_sample = 10'h30C;
        wr(A_CTRL, 16'h8080);
        expect_result("R8", 10'h30C);
        chk("R8", 16'(done_cnt - dc), 16'h1);
        last = 10'h30C;

        // R9 disable aborts
        dc = done_cnt;
        conv_sample = 10'h011;
        wr(A_CTRL, 16'h8080);
        idle(3);
        wr(A_CTRL, 16'h0000);
        chk("R9", {14'b0, conv_busy, adc_on}, 16'h0);
        idle(LAT + 4);
        rdchk("R9", A_DATA, exp_data(1'b0, last));
        chk("R9", 16'(done_cnt - dc), 16'h0);

        finished = 1;
    end

    initial begin
        fork
            begin
                wait (finished);
            end
            begin
                repeat (100000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule